// File: doc/BRIEF.md
# Field-Masked Calendar Alarm Comparator

This block watches the running calendar of a real-time clock and raises an alarm when a software-chosen set of fields equals the current time. Six alarm registers each hold a BCD compare value and a private enable bit, for seconds, minutes, hours, weekday, day of month and month. Any subset of the six can take part in the match; a field whose enable bit is clear has no effect.

The counter block supplies the current BCD field values and a single-cycle pulse once per second. The comparison is made only on that pulse. A full match of every enabled field sets a sticky alarm flag, which software clears through the control register. An interrupt request follows the flag whenever the alarm interrupt enable is set. Registers are written with a one-cycle write strobe and read through a registered read port with one cycle of latency.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset all six alarm registers, the alarm flag, the interrupt enable, the interrupt request and the read data are zero.
- R2: The alarm registers sit at indices 8 (seconds), 9 (minutes), 10 (hours), 11 (weekday), 12 (day) and 13 (month); a write stores the full byte, bit 7 being the field enable and bits 6:0 the BCD compare value, and reading the index returns that byte on rd_data one cycle after rd_addr is presented.
- R3: Index 14 is the control register: bit 0 reads the alarm flag, bit 3 reads the interrupt enable, all other bits read 0; any index other than 8 to 14 reads 0 and writes to it change nothing.
- R4: In a cycle with sec_tick high, if at least one field is enabled and every enabled field's bits 6:0 equal the corresponding current value, the alarm flag is 1 from the next cycle; a month value in the range 1 to 12 (BCD 0x01 to 0x12) is compared like any other field.
- R5: A field whose enable bit is 0 is excluded from the match whatever its stored value and whatever its current value.
- R6: When no field is enabled, a tick never sets the alarm flag, even if every stored value equals the current values.
- R7: Without sec_tick the flag is never set, however long the enabled fields match.
- R8: The alarm flag stays 1 until a write to index 14 with bit 0 equal to 0; a write with bit 0 equal to 1 leaves it unchanged. A write to index 14 loads bit 3 into the interrupt enable.
- R9: alarm_irq equals the alarm flag ANDed with the interrupt enable and changes in the same cycle as either of them.
- R10: When a tick with a full match and a control write clearing the flag fall in the same cycle, the flag is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle pulse once per second from the counter block |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD |
| cur_wday | input | 7 | Current weekday, BCD |
| cur_day | input | 7 | Current day of month, BCD |
| cur_mon | input | 7 | Current month 1 to 12, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read index |
| rd_data | output | 8 | Registered read data, one cycle after rd_addr |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt request |

## Verification
The flag can be set by a matching tick and cleared by a software write to the control register in the very same cycle. The bench provokes this by asserting sec_tick while the enabled fields match and, on that same clock, writing 0x08 to index 14; it then expects the flag and the request still set on the following cycle, and a separate plain clear afterwards to drop both. A reference model in the scoreboard applies set-before-clear priority independently, so either ordering mistake in the design is reported.

// File: rtl/alarm_cmp_pkg.sv
`timescale 1ns/1ps
package alarm_cmp_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int DATA_W     = 8;
  localparam int VAL_W      = DATA_W - 1;
  localparam int ADDR_W     = 4;
  localparam int FIRST_IDX  = 8;
  localparam int CTL_IDX    = 14;
  localparam int FLAG_BIT   = 0;
  localparam int IE_BIT     = 3;

  typedef enum logic [2:0] {
    FLD_SEC  = 3'd0,
    FLD_MIN  = 3'd1,
    FLD_HOUR = 3'd2,
    FLD_WDAY = 3'd3,
    FLD_DAY  = 3'd4,
    FLD_MON  = 3'd5
  } field_e;
endpackage

// File: rtl/alarm_field_slot.sv
`timescale 1ns/1ps
module alarm_field_slot #(
  parameter int DATA_W = alarm_cmp_pkg::DATA_W,
  localparam int VAL_W = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [VAL_W-1:0]  cur_val,
  output logic [DATA_W-1:0] slot_q,
  output logic              armed,
  output logic              hit
);
  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
    end else if (wr_sel) begin
      slot_q <= wr_data;
    end
  end

  // Enable bit is the top bit, value below it.
  assign armed = slot_q[DATA_W-1];
  assign hit   = !armed || (slot_q[VAL_W-1:0] == cur_val);
endmodule

// File: rtl/alarm_flag_ctrl.sv
`timescale 1ns/1ps
module alarm_flag_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic match,
  input  logic ctl_wr,
  input  logic ctl_flag_bit,
  input  logic ctl_ie_bit,
  output logic flag_q,
  output logic ie_q,
  output logic irq_q
);
  logic flag_d;
  logic ie_d;

  always_comb begin
    flag_d = flag_q;
    // Setting has priority over a same-cycle software clear.
    if (tick && match) begin
      flag_d = 1'b1;
    end else if (ctl_wr && !ctl_flag_bit) begin
      flag_d = 1'b0;
    end
    ie_d = ctl_wr ? ctl_ie_bit : ie_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      ie_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_q  <= flag_d && ie_d;
    end
  end

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(ctl_wr && !ctl_flag_bit)) |=> flag_q);

  assert_set_only_on_tick_R7: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !(tick && match)) |=> !flag_q);

  assert_irq_gated_R9: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> (flag_q && ie_q));

  assert_set_beats_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (tick && match) |=> flag_q);

  assert_ie_load_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> (ie_q == $past(ctl_ie_bit)));
endmodule

// File: rtl/alarm_read_mux.sv
`timescale 1ns/1ps
module alarm_read_mux #(
  parameter int NUM_FIELDS = alarm_cmp_pkg::NUM_FIELDS,
  parameter int DATA_W     = alarm_cmp_pkg::DATA_W,
  parameter int ADDR_W     = alarm_cmp_pkg::ADDR_W,
  parameter int FIRST_IDX  = alarm_cmp_pkg::FIRST_IDX,
  parameter int CTL_IDX    = alarm_cmp_pkg::CTL_IDX,
  parameter int FLAG_BIT   = alarm_cmp_pkg::FLAG_BIT,
  parameter int IE_BIT     = alarm_cmp_pkg::IE_BIT,
  localparam int BUS_W     = NUM_FIELDS * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [BUS_W-1:0]  slots,
  input  logic              flag,
  input  logic              ie,
  output logic [DATA_W-1:0] rd_q
);
  logic [DATA_W-1:0] rd_d;

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (rd_addr == ADDR_W'(FIRST_IDX + i)) begin
        rd_d = slots[i*DATA_W +: DATA_W];
      end
    end
    if (rd_addr == ADDR_W'(CTL_IDX)) begin
      rd_d[FLAG_BIT] = flag;
      rd_d[IE_BIT]   = ie;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      rd_q <= rd_d;
    end
  end
endmodule

// File: rtl/alarm_match_unit.sv
`timescale 1ns/1ps
module alarm_match_unit
  import alarm_cmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [VAL_W-1:0]  cur_sec,
  input  logic [VAL_W-1:0]  cur_min,
  input  logic [VAL_W-1:0]  cur_hour,
  input  logic [VAL_W-1:0]  cur_wday,
  input  logic [VAL_W-1:0]  cur_day,
  input  logic [VAL_W-1:0]  cur_mon,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              alarm_flag,
  output logic              alarm_irq
);
  localparam int BUS_W = NUM_FIELDS * DATA_W;

  logic [VAL_W-1:0]      cur_arr [NUM_FIELDS];
  logic [NUM_FIELDS-1:0] slot_sel;
  logic [NUM_FIELDS-1:0] slot_armed;
  logic [NUM_FIELDS-1:0] slot_hit;
  logic [BUS_W-1:0]      slot_bus;
  logic                  full_match;
  logic                  ctl_wr;
  logic                  ie_state;

  always_comb begin
    cur_arr[FLD_SEC]  = cur_sec;
    cur_arr[FLD_MIN]  = cur_min;
    cur_arr[FLD_HOUR] = cur_hour;
    cur_arr[FLD_WDAY] = cur_wday;
    cur_arr[FLD_DAY]  = cur_day;
    cur_arr[FLD_MON]  = cur_mon;
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
    assign slot_sel[g] = wr_en && (wr_addr == ADDR_W'(FIRST_IDX + g));

    alarm_field_slot #(.DATA_W(DATA_W)) i_slot (
      .clk     (clk),
      .rst     (rst),
      .wr_sel  (slot_sel[g]),
      .wr_data (wr_data),
      .cur_val (cur_arr[g]),
      .slot_q  (slot_bus[g*DATA_W +: DATA_W]),
      .armed   (slot_armed[g]),
      .hit     (slot_hit[g])
    );
  end

  // A match needs at least one armed field.
  assign full_match = (|slot_armed) && (&slot_hit);
  assign ctl_wr     = wr_en && (wr_addr == ADDR_W'(CTL_IDX));

  alarm_flag_ctrl i_ctrl (
    .clk          (clk),
    .rst          (rst),
    .tick         (sec_tick),
    .match        (full_match),
    .ctl_wr       (ctl_wr),
    .ctl_flag_bit (wr_data[FLAG_BIT]),
    .ctl_ie_bit   (wr_data[IE_BIT]),
    .flag_q       (alarm_flag),
    .ie_q         (ie_state),
    .irq_q        (alarm_irq)
  );

  alarm_read_mux #(
    .NUM_FIELDS (NUM_FIELDS),
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .FIRST_IDX  (FIRST_IDX),
    .CTL_IDX    (CTL_IDX),
    .FLAG_BIT   (FLAG_BIT),
    .IE_BIT     (IE_BIT)
  ) i_rdmux (
    .clk     (clk),
    .rst     (rst),
    .rd_addr (rd_addr),
    .slots   (slot_bus),
    .flag    (alarm_flag),
    .ie      (ie_state),
    .rd_q    (rd_data)
  );

  assert_no_fire_unarmed_R6: assert property (@(posedge clk) disable iff (rst)
    (!alarm_flag && (slot_armed == '0)) |=> !alarm_flag);

  assert_disarmed_slot_hits_R5: assert property (@(posedge clk) disable iff (rst)
    $fell(slot_armed[FLD_SEC]) |-> slot_hit[FLD_SEC]);
endmodule

// File: tb/test_alarm_match_unit.sv
`timescale 1ns/1ps
module test_alarm_match_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [6:0] cur_m [6];
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       alarm_flag;
  logic       alarm_irq;

  always #2.5 clk = ~clk;

  alarm_match_unit i_alarm_match_unit (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .cur_sec(cur_m[0]), .cur_min(cur_m[1]), .cur_hour(cur_m[2]),
    .cur_wday(cur_m[3]), .cur_day(cur_m[4]), .cur_mon(cur_m[5]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
  );

  typedef struct {
    logic [7:0] rd;
    logic       fl;
    logic       iq;
    string      tag;
  } exp_t;

  exp_t sb [$];
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Reference state built from the requirements.
  logic [7:0] m_regs [6];
  logic       m_flag;
  logic       m_ie;

  function automatic logic [7:0] rd_model(input logic [3:0] a);
    if (a >= 4'd8 && a <= 4'd13) return m_regs[int'(a) - 8];
    if (a == 4'd14) return {4'b0, m_ie, 2'b0, m_flag};
    return 8'h00;
  endfunction

  function automatic logic match_model();
    logic any = 1'b0;
    logic ok  = 1'b1;
    for (int i = 0; i < 6; i++) begin
      if (m_regs[i][7]) begin
        any = 1'b1;
        if (m_regs[i][6:0] != cur_m[i]) ok = 1'b0;
      end
    end
    return any && ok;
  endfunction

  task automatic step(input logic tk, input logic we, input logic [3:0] wa,
                      input logic [7:0] wd, input logic [3:0] ra, input string tag);
    exp_t e;
    logic m;
    @(negedge clk);
    sec_tick = tk; wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra;
    e.rd = rd_model(ra);
    m = match_model();
    if (we && wa >= 4'd8 && wa <= 4'd13) m_regs[int'(wa) - 8] = wd;
    if (tk && m) m_flag = 1'b1;
    else if (we && wa == 4'd14 && !wd[0]) m_flag = 1'b0;
    if (we && wa == 4'd14) m_ie = wd[3];
    e.fl = m_flag; e.iq = m_flag && m_ie; e.tag = tag;
    @(posedge clk);
    #1;
    sb.push_back(e);
  endtask

  task automatic idle(input logic [3:0] ra, input string tag);
    step(1'b0, 1'b0, 4'd0, 8'h00, ra, tag);
  endtask

  // Scoreboard monitor.
  always @(negedge clk) begin
    if (sb.size() != 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (rd_data !== e.rd || alarm_flag !== e.fl || alarm_irq !== e.iq) begin
        fails++;
        $display("FAIL %s: rd=%02h flag=%0b irq=%0b expected rd=%02h flag=%0b irq=%0b",
                 e.tag, rd_data, alarm_flag, alarm_irq, e.rd, e.fl, e.iq);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 6; i++) begin
      cur_m[i] = 7'h00;
      m_regs[i] = 8'h00;
    end
    m_flag = 1'b0;
    m_ie = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    checks++;
    if (alarm_flag !== 1'b0 || alarm_irq !== 1'b0 || rd_data !== 8'h00) begin
      fails++;
      $display("FAIL R1 reset outputs: flag=%0b irq=%0b rd=%02h expected 0 0 00",
               alarm_flag, alarm_irq, rd_data);
    end
    idle(4'd14, "R1 control reads zero");
    for (int a = 8; a <= 13; a++) idle(4'(a), "R1 alarm register zero");

    // R2 load and read back
    step(0, 1, 4'd8,  8'hB0, 4'd0, "R2 write seconds");
    step(0, 1, 4'd9,  8'h05, 4'd0, "R2 write minutes disabled");
    step(0, 1, 4'd10, 8'h00, 4'd0, "R2 write hours");
    step(0, 1, 4'd11, 8'h00, 4'd0, "R2 write weekday");
    step(0, 1, 4'd12, 8'h00, 4'd0, "R2 write day");
    step(0, 1, 4'd13, 8'h00, 4'd0, "R2 write month");
    for (int a = 8; a <= 13; a++) idle(4'(a), "R2 readback");

    // R3 unmapped index
    step(0, 1, 4'd3, 8'hFF, 4'd3, "R3 unmapped write");
    idle(4'd3, "R3 unmapped reads zero");

    // R4 / R5 seconds-only alarm with a disabled minutes field
    cur_m[0] = 7'h29; cur_m[1] = 7'h44;
    step(1, 0, 4'd0, 8'h00, 4'd0, "R4 seconds mismatch");
    cur_m[0] = 7'h30;
    step(1, 0, 4'd0, 8'h00, 4'd0, "R4 R5 seconds match fires");
    idle(4'd14, "R3 control shows flag");

    // R8 sticky flag and clear
    step(0, 1, 4'd14, 8'h01, 4'd14, "R8 writing one keeps flag");
    step(0, 1, 4'd14, 8'h08, 4'd14, "R8 clear flag, set enable");
    idle(4'd14, "R3 control shows enable");

    // R7 match without tick
    for (int k = 0; k < 3; k++) idle(4'd0, "R7 no tick no flag");

    // R9 request follows flag and enable
    step(1, 0, 4'd0, 8'h00, 4'd0, "R9 irq with enable");

    // R10 tick and clear in one cycle
    step(1, 1, 4'd14, 8'h08, 4'd14, "R10 set beats clear");
    step(0, 1, 4'd14, 8'h00, 4'd14, "R8 R9 clear drops irq");

    // R6 nothing armed, all values equal
    step(0, 1, 4'd8, 8'h30, 4'd0, "R6 disarm seconds");
    cur_m[1] = 7'h05;
    step(1, 0, 4'd0, 8'h00, 4'd0, "R6 no armed field");
    step(1, 0, 4'd0, 8'h00, 4'd14, "R6 no armed field again");

    // R4 multi-field with month 12
    step(0, 1, 4'd10, 8'hA3, 4'd0, "R4 arm hour 23");
    step(0, 1, 4'd12, 8'hB1, 4'd0, "R4 arm day 31");
    step(0, 1, 4'd13, 8'h92, 4'd0, "R4 arm month 12");
    step(0, 1, 4'd14, 8'h08, 4'd0, "R9 enable again");
    cur_m[2] = 7'h23; cur_m[4] = 7'h31; cur_m[5] = 7'h11;
    step(1, 0, 4'd0, 8'h00, 4'd0, "R4 month mismatch");
    cur_m[5] = 7'h12;
    step(1, 0, 4'd0, 8'h00, 4'd13, "R4 month 12 fires");
    idle(4'd14, "R9 control and irq");

    idle(4'd0, "final idle");
    @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule